// File: doc/BRIEF.md
# Time-Shared Half-Width Unsigned Multiplier

This block forms the full unsigned product of two operands with a single multiplier of half the operand width. Each operand is cut into an upper and a lower half. The four half-by-half products are formed one per clock cycle. Each product is shifted to its weight and added into an accumulator twice the operand width. The block gives one product per multi-cycle operation, so it suits paths that do not need a new result on every clock.

A caller presents both operands with a one-cycle `start`. The block raises `busy` for the four working cycles, then pulses `done` for one cycle. At that point `product` holds the result. It stays there until the next accepted start. With the default width of 32, the block uses one 16x16 multiplier.

The controller has five states:

- `PH_IDLE` is the waiting state. It moves to `PH_LL` when `start` is high, and otherwise stays where it is.
- `PH_LL` adds low·low with no shift, then moves to `PH_HL`.
- `PH_HL` adds high(p)·low(q), shifted up by one half-width, then moves to `PH_LH`.
- `PH_LH` adds low(p)·high(q), shifted up by one half-width, then moves to `PH_HH`.
- `PH_HH` adds high·high, shifted up by two half-widths, then returns to `PH_IDLE`, and `done` is raised for the following cycle.

Top module: `split_mul_seq`

## Requirements
- R1: When `done` is high, `product` equals the full unsigned product `op_p * op_q` of the operands captured at the accepted start, with no bits lost.
- R2: The four partial products go through one shared half-width multiplier, in the fixed order low·low, high(p)·low(q), low(p)·high(q), high·high. Their shifts are 0, one half-width, one half-width and two half-widths.
- R3: A `start` seen in `PH_IDLE` is accepted at that clock edge. In the next cycle `busy` is 1 and `product` reads 0, because the accumulator is cleared.
- R4: `busy` stays high for exactly four cycles after an accepted start. `done` is high for exactly one cycle, in the fifth cycle after the start edge, and `busy` is 0 in that cycle.
- R5: A `start` that arrives while `busy` is high is ignored. The running operation keeps its operands, its result and its timing, and no second operation follows.
- R6: After `done`, `product` holds its value for as long as no new start is accepted.
- R7: During reset and just after it, `busy` = 0, `done` = 0 and `product` = 0.
- R8: Boundary operands give exact results: 0·x = 0, 1·x = x, and all-ones times all-ones = 2^(2W) − 2^(W+1) + 1. For W = 32 that value is 0xFFFFFFFE00000001.
- R9: A `start` raised in the cycle where `done` is high is accepted. The next operation runs immediately, back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the present operands (taken only when idle) |
| op_p | input | OP_W | First unsigned operand |
| op_q | input | OP_W | Second unsigned operand |
| busy | output | 1 | High while partial products are being accumulated |
| done | output | 1 | One-cycle pulse when `product` is complete |
| product | output | 2*OP_W | Accumulated unsigned product |

## Verification
The bench builds two copies of the block. The default 32-bit copy runs zero, one, all-ones squared, a run of random pairs, a start that arrives mid-operation, and checks of hold and timing. The second copy is built with 6-bit operands, which gives a 3x3 shared multiplier. That small size makes all 4096 operand pairs reachable in one back-to-back sweep, so every carry path through the shifted cross terms is checked against arithmetic done in the bench.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LL   = 3'd1,
        PH_HL   = 3'd2,
        PH_LH   = 3'd3,
        PH_HH   = 3'd4
    } phase_t;

    // Weight of each partial product, counted in half-widths.
    function automatic logic [1:0] phase_weight(input phase_t ph);
        logic [1:0] w;
        unique case (ph)
            PH_HL, PH_LH: w = 2'd1;
            PH_HH:        w = 2'd2;
            default:      w = 2'd0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/split_mul_ctrl.sv
module split_mul_ctrl
    import split_mul_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output phase_t phase_o,
    output logic   busy_o,
    output logic   done_o,
    output logic   load_o,
    output logic   clr_o,
    output logic   add_o
);

    phase_t state_q, state_d;
    logic   done_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == PH_HH);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (start_i) state_d = PH_LL;
            PH_LL:   state_d = PH_HL;
            PH_HL:   state_d = PH_LH;
            PH_LH:   state_d = PH_HH;
            PH_HH:   state_d = PH_IDLE;
            default: state_d = PH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        phase_o = state_q;
        busy_o  = (state_q != PH_IDLE);
        load_o  = (state_q == PH_IDLE) && start_i;
        clr_o   = load_o;
        add_o   = busy_o;
        done_o  = done_q;
    end

    // R4: busy lasts four cycles; only the last phase drops it
    a_r4_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != PH_HH) |=> busy_o);

    // R4: done is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: done and busy are never high together
    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, busy_o}));

endmodule

// File: rtl/split_mul_operands.sv
module split_mul_operands
    import split_mul_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int OP_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              busy_i,
    input  logic [OP_W-1:0]   p_i,
    input  logic [OP_W-1:0]   q_i,
    input  phase_t            phase_i,
    output logic [HALF_W-1:0] x_o,
    output logic [HALF_W-1:0] y_o,
    output logic [OP_W-1:0]   p_q,
    output logic [OP_W-1:0]   q_q
);

    logic x_upper, y_upper;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
            q_q <= '0;
        end else if (load_i) begin
            p_q <= p_i;
            q_q <= q_i;
        end
    end

    // Half selection per phase: HL and HH take upper p; LH and HH take upper q
    always_comb begin
        x_upper = (phase_i == PH_HL) || (phase_i == PH_HH);
        y_upper = (phase_i == PH_LH) || (phase_i == PH_HH);
        x_o = x_upper ? p_q[OP_W-1:HALF_W] : p_q[HALF_W-1:0];
        y_o = y_upper ? q_q[OP_W-1:HALF_W] : q_q[HALF_W-1:0];
    end

    // R5: operands held for the whole operation, whatever start does
    a_r5_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(p_q) && $stable(q_q)));

endmodule

// File: rtl/split_mul_half_mult.sv
module split_mul_half_mult #(
    parameter int HALF_W = 16,
    localparam int PP_W  = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] x_i,
    input  logic [HALF_W-1:0] y_i,
    output logic [PP_W-1:0]   pp_o
);

    always_comb begin
        pp_o = {{HALF_W{1'b0}}, x_i} * {{HALF_W{1'b0}}, y_i};
    end

endmodule

// File: rtl/split_mul_accum.sv
module split_mul_accum #(
    parameter int HALF_W = 16,
    localparam int PP_W  = 2 * HALF_W,
    localparam int ACC_W = 4 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic [PP_W-1:0]  pp_i,
    input  logic [1:0]       weight_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] pp_ext;
    logic [ACC_W-1:0] pp_shifted;

    always_comb begin
        pp_ext = {{PP_W{1'b0}}, pp_i};
        unique case (weight_i)
            2'd1:    pp_shifted = pp_ext << HALF_W;
            2'd2:    pp_shifted = pp_ext << (2 * HALF_W);
            default: pp_shifted = pp_ext;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clr_i) begin
            acc_o <= '0;
        end else if (add_i) begin
            acc_o <= acc_o + pp_shifted;
        end
    end

    // R3: clearing empties the accumulator
    a_r3_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));

    // R6: without clear or add the sum holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !add_i) |=> $stable(acc_o));

endmodule

// File: rtl/split_mul_seq.sv
module split_mul_seq
    import split_mul_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_p,
    input  logic [OP_W-1:0]   op_q,
    output logic              busy,
    output logic              done,
    output logic [2*OP_W-1:0] product
);

    localparam int HALF_W = OP_W / 2;
    localparam int PP_W   = 2 * HALF_W;
    localparam int PROD_W = 2 * OP_W;

    phase_t            phase;
    logic              load, clr, add;
    logic [HALF_W-1:0] mx, my;
    logic [PP_W-1:0]   pp;
    logic [1:0]        weight;
    logic [OP_W-1:0]   p_held, q_held;

    split_mul_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .phase_o (phase),
        .busy_o  (busy),
        .done_o  (done),
        .load_o  (load),
        .clr_o   (clr),
        .add_o   (add)
    );

    split_mul_operands #(.HALF_W(HALF_W)) u_ops (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .busy_i  (busy),
        .p_i     (op_p),
        .q_i     (op_q),
        .phase_i (phase),
        .x_o     (mx),
        .y_o     (my),
        .p_q     (p_held),
        .q_q     (q_held)
    );

    split_mul_half_mult #(.HALF_W(HALF_W)) u_mult (
        .x_i  (mx),
        .y_i  (my),
        .pp_o (pp)
    );

    always_comb weight = phase_weight(phase);

    split_mul_accum #(.HALF_W(HALF_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .add_i    (add),
        .pp_i     (pp),
        .weight_i (weight),
        .acc_o    (product)
    );

    // R1: completed sum equals the full-width product of the held operands
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ({{OP_W{1'b0}}, p_held} * {{OP_W{1'b0}}, q_held})));

    // R3: the first busy cycle starts from an empty accumulator
    a_r3_empty_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (product == {PROD_W{1'b0}}));

endmodule

// File: tb/split_mul_seq_test.sv
module split_mul_seq_test;

    localparam int W  = 32;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start = 1'b0;
    logic [W-1:0]  op_p = '0, op_q = '0;
    logic          busy, done;
    logic [2*W-1:0] product;

    logic           s_start = 1'b0;
    logic [SW-1:0]  s_p = '0, s_q = '0;
    logic           s_busy, s_done;
    logic [2*SW-1:0] s_product;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    split_mul_seq #(.OP_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_p(op_p), .op_q(op_q),
        .busy(busy), .done(done), .product(product)
    );

    split_mul_seq #(.OP_W(SW)) uut_sweep (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op_p(s_p), .op_q(s_q),
        .busy(s_busy), .done(s_done), .product(s_product)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        return {32'b0, a} * {32'b0, b};
    endfunction

    // One full operation on the 32-bit copy, with timing checks
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [63:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        op_p = a; op_q = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && product == 64'd0, "R3 start accepted, cleared",
            {62'd0, busy, done}, 64'd2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(busy == 1'b1 && done == 1'b0, "R4 busy span", {62'd0, busy, done}, 64'd2);
        end
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R4 done in fifth cycle", {62'd0, busy, done}, 64'd1);
        chk(product == exp, req, product, exp);
        @(negedge clk);
        chk(done == 1'b0, "R4 done lasts one cycle", {63'd0, done}, 64'd0);
        repeat (3) @(negedge clk);
        chk(product == exp, "R6 result held", product, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        logic [63:0] exp;
        repeat (2) @(negedge clk);
        chk(busy == 0 && done == 0 && product == 0, "R7 reset state", product, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && product == 0, "R7 after reset", product, 64'd0);

        // R8 boundary operands
        run_op(32'd0, 32'hDEADBEEF, "R8 zero times x");
        run_op(32'd1, 32'hCAFEF00D, "R8 one times x");
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, "R8 all ones squared");
        run_op(32'h0000FFFF, 32'hFFFF0000, "R2 cross term carry");
        run_op(32'hFFFF0000, 32'h0000FFFF, "R2 other cross term");

        // R1 random pairs
        for (int k = 0; k < 40; k++) begin
            run_op($urandom, $urandom, "R1 random pair");
        end

        // R5 start while busy is ignored
        exp = ref_mul(32'h12345678, 32'h9ABCDEF0);
        @(negedge clk);
        op_p = 32'h12345678; op_q = 32'h9ABCDEF0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op_p = 32'hFFFFFFFF; op_q = 32'h00000003; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b1, "R5 timing unchanged", {62'd0, busy, done}, 64'd2);
        @(negedge clk);
        chk(done == 1'b1 && product == exp, "R5 first operands kept", product, exp);
        @(negedge clk);
        chk(busy == 1'b0, "R5 no second operation", {63'd0, busy}, 64'd0);

        // R9 and R1: exhaustive back-to-back sweep on the 6-bit copy
        @(negedge clk);
        s_p = '0; s_q = '0; s_start = 1'b1;
        for (int idx = 0; idx < 4096; idx++) begin
            logic [2*SW-1:0] sexp;
            sexp = {6'b0, s_p} * {6'b0, s_q};
            @(negedge clk);
            s_start = 1'b0;
            repeat (3) @(negedge clk);
            @(negedge clk);
            chk(s_done == 1'b1 && s_product == sexp, "R9 R1 sweep product",
                {52'd0, s_product}, {52'd0, sexp});
            if (idx < 4095) begin
                s_p = SW'((idx + 1) % 64);
                s_q = SW'((idx + 1) / 64);
                s_start = 1'b1;
            end
        end
        @(negedge clk);
        chk(s_done == 1'b0 && s_busy == 1'b0, "R4 sweep ends idle",
            {62'd0, s_busy, s_done}, 64'd0);

        finish_up();
    end

endmodule